// File: doc/BRIEF.md
# Load/Store Address and Extension Unit

This unit turns a load or store request into one memory access and prepares the results that go back to the register file. It forms the effective address from a base register and an optional offset. The offset is either a signed 16-bit immediate or the value of a second register. A base register index of zero does not read a register: it contributes the constant zero. For a store, the unit spreads the data across the byte lanes of the word and raises the matching byte enables. For a load, it picks the addressed byte or halfword from the returned word and extends it to full width.

The unit accepts a request only while idle. It issues a single-cycle memory request one cycle later and then waits for the response pulse. One cycle after the response it raises `done_o` for one cycle. In that cycle it also presents the load writeback and, for update forms, the base-register writeback of the effective address. An update form whose base index is zero cannot write anything back, so the unit marks it invalid and suppresses that writeback. The memory access itself still takes place.

Byte lanes are numbered in big-endian order: address offset 0 is bits 31:24 of the data word. Alignment is not checked. The low address bits only steer the lane selection.

Top module: `ldst_agu_unit`

## Requirements
- R1: With `req_mode_i` = 0 (base only) the memory address equals the base value.
- R2: With `req_mode_i` = 1 the memory address equals base plus `imm_i` sign-extended from bit 15.
- R3: With `req_mode_i` = 2 the memory address equals base plus `index_val_i`.
- R4: When `base_idx_i` is 0, the base contribution is 0 in every mode, whatever `base_val_i` holds.
- R5: For an update request (`req_update_i` = 1) with nonzero base index, the done cycle shows `base_we_o` = 1, `base_wb_idx_o` = the base index and `base_wb_val_o` = the effective address; without update, `base_we_o` stays 0.
- R6: An update request with base index 0 raises `invalid_o` in the done cycle and keeps `base_we_o` at 0. The memory access is still made.
- R7: A byte load (`req_size_i` = 0) returns the byte on lane `addr[1:0]`, where lane 0 is bits 31:24 and lane 3 is bits 7:0. It is zero-extended regardless of `req_sext_i`.
- R8: A halfword load (`req_size_i` = 1) returns bits 31:16 when `addr[1]` = 0 and bits 15:0 otherwise. It is zero-extended when `req_sext_i` = 0 and sign-extended from bit 15 when `req_sext_i` = 1.
- R9: A word load (`req_size_i` = 2) returns the response word unchanged.
- R10: A store drives `mem_we_o` = 1 and sets the byte enables by size. A byte store uses `1000 >> addr[1:0]` and repeats the byte four times. A halfword store uses 1100 when `addr[1]` = 0 and 0011 otherwise, and repeats the halfword twice. A word store uses 1111 and the word unchanged. A load drives `mem_we_o` = 0.
- R11: `mem_req_o` is a one-cycle pulse in the cycle after acceptance. `done_o` is a one-cycle pulse in the cycle after `mem_rvalid_i` is sampled high. In that cycle `ld_we_o` is 1 for loads and 0 for stores.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe, sampled while idle |
| req_store_i | input | 1 | 1 = store, 0 = load |
| req_mode_i | input | 2 | 0 base only, 1 base + immediate, 2 base + index |
| req_update_i | input | 1 | Write the effective address back to the base register |
| req_size_i | input | 2 | 0 byte, 1 halfword, 2 word |
| req_sext_i | input | 1 | Sign-extend halfword loads |
| base_idx_i | input | 5 | Base register index (0 means constant zero) |
| base_val_i | input | 32 | Base register contents |
| imm_i | input | 16 | Signed immediate offset |
| index_val_i | input | 32 | Index register contents |
| store_data_i | input | 32 | Store data, right-aligned |
| mem_req_o | output | 1 | Memory request pulse |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | 32 | Memory byte address |
| mem_be_o | output | 4 | Byte enables, bit 3 = lane 0 (bits 31:24) |
| mem_wdata_o | output | 32 | Lane-replicated store data |
| mem_rvalid_i | input | 1 | Memory response pulse |
| mem_rdata_i | input | 32 | Memory read data |
| done_o | output | 1 | Completion pulse |
| ld_we_o | output | 1 | Load result valid for writeback |
| ld_data_o | output | 32 | Extended load result |
| base_we_o | output | 1 | Base register writeback enable |
| base_wb_idx_o | output | 5 | Base register writeback index |
| base_wb_val_o | output | 32 | Base register writeback value |
| invalid_o | output | 1 | Update form with base index 0 |

## Verification
The bench builds the unit with its default widths: a 32-bit address and data path, 5-bit register indices and a 16-bit immediate. At this size the whole control space can be swept. The sweep covers every mode, zero and nonzero base index, update on and off, all three sizes, every byte offset, both sign-extend settings, loads and stores, and response latencies of one to three cycles. Two response patterns put a negative and a positive value in each halfword and mix the byte signs. A negative immediate exercises sign extension of the offset.

// File: rtl/ldst_pkg.sv
package ldst_pkg;
  typedef enum logic [1:0] {AM_BASE = 2'd0, AM_IMM = 2'd1, AM_IDX = 2'd2} amode_e;
  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2} asize_e;
  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT, ST_DONE} fsm_e;
endpackage

// File: rtl/ldst_ea_calc.sv
module ldst_ea_calc #(
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 16,
  parameter int RIDX_W = 5
) (
  input  ldst_pkg::amode_e    mode_i,
  input  logic [RIDX_W-1:0]   base_idx_i,
  input  logic [ADDR_W-1:0]   base_val_i,
  input  logic [IMM_W-1:0]    imm_i,
  input  logic [ADDR_W-1:0]   index_val_i,
  output logic [ADDR_W-1:0]   ea_o,
  output logic                base_zero_o
);
  import ldst_pkg::*;

  logic [ADDR_W-1:0] base_eff, offs;

  assign base_zero_o = (base_idx_i == '0);
  assign base_eff    = base_zero_o ? '0 : base_val_i;

  always_comb begin
    unique case (mode_i)
      AM_IMM:  offs = {{(ADDR_W-IMM_W){imm_i[IMM_W-1]}}, imm_i};
      AM_IDX:  offs = index_val_i;
      default: offs = '0;
    endcase
  end

  assign ea_o = base_eff + offs;
endmodule

// File: rtl/ldst_lane_fmt.sv
module ldst_lane_fmt #(
  parameter int DATA_W = 32,
  localparam int NB     = DATA_W / 8,
  localparam int NH     = NB / 2,
  localparam int LANE_W = $clog2(NB),
  localparam int SH_W   = $clog2(DATA_W)
) (
  input  ldst_pkg::asize_e    size_i,
  input  logic                sext_i,
  input  logic [LANE_W-1:0]   lane_i,
  input  logic [DATA_W-1:0]   rdata_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   ld_data_o,
  output logic [DATA_W-1:0]   st_data_o,
  output logic [NB-1:0]       st_be_o
);
  import ldst_pkg::*;

  logic [LANE_W-2:0] half_lane;
  logic [SH_W-1:0]   b_sh, h_sh;
  logic [7:0]        byte_v;
  logic [15:0]       half_v;

  assign half_lane = lane_i[LANE_W-1:1];
  // big-endian: lane 0 sits in the top byte
  assign b_sh   = SH_W'((NB - 1 - int'(lane_i)) * 8);
  assign h_sh   = SH_W'((NH - 1 - int'(half_lane)) * 16);
  assign byte_v = 8'(rdata_i >> b_sh);
  assign half_v = 16'(rdata_i >> h_sh);

  always_comb begin
    unique case (size_i)
      SZ_BYTE: begin
        ld_data_o = {{(DATA_W-8){1'b0}}, byte_v};
        st_data_o = {NB{wdata_i[7:0]}};
        st_be_o   = {1'b1, {(NB-1){1'b0}}} >> lane_i;
      end
      SZ_HALF: begin
        ld_data_o = {{(DATA_W-16){sext_i & half_v[15]}}, half_v};
        st_data_o = {NH{wdata_i[15:0]}};
        st_be_o   = {2'b11, {(NB-2){1'b0}}} >> {half_lane, 1'b0};
      end
      default: begin
        ld_data_o = rdata_i;
        st_data_o = wdata_i;
        st_be_o   = '1;
      end
    endcase
  end
endmodule

// File: rtl/ldst_agu_unit.sv
module ldst_agu_unit #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int RIDX_W = 5,
  parameter int IMM_W  = 16,
  localparam int NB     = DATA_W / 8,
  localparam int LANE_W = $clog2(NB)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_store_i,
  input  logic [1:0]        req_mode_i,
  input  logic              req_update_i,
  input  logic [1:0]        req_size_i,
  input  logic              req_sext_i,
  input  logic [RIDX_W-1:0] base_idx_i,
  input  logic [ADDR_W-1:0] base_val_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [ADDR_W-1:0] index_val_i,
  input  logic [DATA_W-1:0] store_data_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [NB-1:0]     mem_be_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_rvalid_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              done_o,
  output logic              ld_we_o,
  output logic [DATA_W-1:0] ld_data_o,
  output logic              base_we_o,
  output logic [RIDX_W-1:0] base_wb_idx_o,
  output logic [ADDR_W-1:0] base_wb_val_o,
  output logic              invalid_o
);
  import ldst_pkg::*;

  fsm_e              state_q;
  logic [ADDR_W-1:0] ea_d, ea_q;
  logic              bzero_d, bzero_q;
  logic              store_q, upd_q, sext_q;
  asize_e            size_q;
  logic [RIDX_W-1:0] bidx_q;
  logic [DATA_W-1:0] wdata_q, ld_q, ld_fmt, st_fmt;
  logic [NB-1:0]     st_be;
  logic              accept;

  ldst_ea_calc #(.ADDR_W(ADDR_W), .IMM_W(IMM_W), .RIDX_W(RIDX_W)) u_ea (
    .mode_i      (amode_e'(req_mode_i)),
    .base_idx_i  (base_idx_i),
    .base_val_i  (base_val_i),
    .imm_i       (imm_i),
    .index_val_i (index_val_i),
    .ea_o        (ea_d),
    .base_zero_o (bzero_d)
  );

  ldst_lane_fmt #(.DATA_W(DATA_W)) u_fmt (
    .size_i    (size_q),
    .sext_i    (sext_q),
    .lane_i    (ea_q[LANE_W-1:0]),
    .rdata_i   (mem_rdata_i),
    .wdata_i   (wdata_q),
    .ld_data_o (ld_fmt),
    .st_data_o (st_fmt),
    .st_be_o   (st_be)
  );

  assign accept = (state_q == ST_IDLE) && req_valid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ea_q    <= '0;
      bzero_q <= 1'b0;
      store_q <= 1'b0;
      upd_q   <= 1'b0;
      sext_q  <= 1'b0;
      size_q  <= SZ_WORD;
      bidx_q  <= '0;
      wdata_q <= '0;
      ld_q    <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE:  if (accept) state_q <= ST_ISSUE;
        ST_ISSUE: state_q <= ST_WAIT;
        ST_WAIT:  if (mem_rvalid_i) state_q <= ST_DONE;
        default:  state_q <= ST_IDLE;
      endcase
      if (accept) begin
        ea_q    <= ea_d;
        bzero_q <= bzero_d;
        store_q <= req_store_i;
        upd_q   <= req_update_i;
        sext_q  <= req_sext_i;
        size_q  <= asize_e'(req_size_i);
        bidx_q  <= base_idx_i;
        wdata_q <= store_data_i;
      end
      if (state_q == ST_WAIT && mem_rvalid_i) ld_q <= ld_fmt;
    end
  end

  assign mem_req_o     = (state_q == ST_ISSUE);
  assign mem_we_o      = mem_req_o & store_q;
  assign mem_addr_o    = ea_q;
  assign mem_be_o      = mem_req_o ? st_be : '0;
  assign mem_wdata_o   = st_fmt;

  assign done_o        = (state_q == ST_DONE);
  assign ld_we_o       = done_o & ~store_q;
  assign ld_data_o     = ld_q;
  assign base_we_o     = done_o & upd_q & ~bzero_q;
  assign invalid_o     = done_o & upd_q & bzero_q;
  assign base_wb_idx_o = bidx_q;
  assign base_wb_val_o = ea_q;

  a_r11_req_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o);
  a_r11_done_after_rsp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(mem_rvalid_i));
  a_r11_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r1_addr_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT) |-> $stable(mem_addr_o));
  a_r5_wb_in_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    base_we_o |-> done_o && base_wb_idx_o != '0);
  a_r6_invalid_no_wb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    invalid_o |-> !base_we_o && base_wb_idx_o == '0);
  a_r10_be_shape: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> ($countones(mem_be_o) == 1 || $countones(mem_be_o) == 2 ||
                   $countones(mem_be_o) == NB));
  a_r7_byte_zext: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_we_o && size_q == SZ_BYTE) |-> ld_data_o[DATA_W-1:8] == '0);
  a_r8_half_zext: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_we_o && size_q == SZ_HALF && !sext_q) |-> ld_data_o[DATA_W-1:16] == '0);
endmodule

// File: tb/ldst_agu_unit_tb.sv
module ldst_agu_unit_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0, req_store_i = 1'b0, req_update_i = 1'b0, req_sext_i = 1'b0;
  logic [1:0]  req_mode_i = '0, req_size_i = '0;
  logic [4:0]  base_idx_i = '0;
  logic [31:0] base_val_i = '0, index_val_i = '0, store_data_i = '0, mem_rdata_i = '0;
  logic [15:0] imm_i = '0;
  logic        mem_rvalid_i = 1'b0;
  logic        mem_req_o, mem_we_o, done_o, ld_we_o, base_we_o, invalid_o;
  logic [31:0] mem_addr_o, mem_wdata_o, ld_data_o, base_wb_val_o;
  logic [3:0]  mem_be_o;
  logic [4:0]  base_wb_idx_o;

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  always #5 clk_i = ~clk_i;

  ldst_agu_unit u_dut (
    .clk_i, .rst_ni, .req_valid_i, .req_store_i, .req_mode_i, .req_update_i,
    .req_size_i, .req_sext_i, .base_idx_i, .base_val_i, .imm_i, .index_val_i,
    .store_data_i, .mem_req_o, .mem_we_o, .mem_addr_o, .mem_be_o, .mem_wdata_o,
    .mem_rvalid_i, .mem_rdata_i, .done_o, .ld_we_o, .ld_data_o, .base_we_o,
    .base_wb_idx_o, .base_wb_val_o, .invalid_o
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic do_op(input bit st, input int mode, input bit upd, input int sz,
                       input bit sx, input logic [4:0] bidx, input logic [31:0] bval,
                       input logic [15:0] imm, input logic [31:0] idx,
                       input logic [31:0] wd, input logic [31:0] rw, input int lat);
    logic [31:0] base, ea, exp_ld, exp_wd;
    logic [15:0] h;
    logic [3:0]  exp_be;
    string       atag;
    base = (bidx == 0) ? 32'h0 : bval;
    case (mode)
      1: begin ea = base + {{16{imm[15]}}, imm}; atag = "R2"; end
      2: begin ea = base + idx;                  atag = "R3"; end
      default: begin ea = base;                  atag = "R1"; end
    endcase
    if (bidx == 0) atag = "R4";
    case (sz)
      0: begin
        exp_ld = (rw >> (8 * (3 - int'(ea[1:0])))) & 32'hFF;
        exp_be = 4'b1000 >> ea[1:0];
        exp_wd = {4{wd[7:0]}};
      end
      1: begin
        h      = ea[1] ? rw[15:0] : rw[31:16];
        exp_ld = (sx && h[15]) ? {16'hFFFF, h} : {16'h0, h};
        exp_be = ea[1] ? 4'b0011 : 4'b1100;
        exp_wd = {2{wd[15:0]}};
      end
      default: begin exp_ld = rw; exp_be = 4'b1111; exp_wd = wd; end
    endcase

    @(negedge clk_i);
    req_valid_i = 1'b1; req_store_i = st; req_mode_i = 2'(mode); req_update_i = upd;
    req_size_i = 2'(sz); req_sext_i = sx; base_idx_i = bidx; base_val_i = bval;
    imm_i = imm; index_val_i = idx; store_data_i = wd;
    @(posedge clk_i); #1;
    chk("R11 mem_req", 32'(mem_req_o), 32'd1);
    chk(atag, mem_addr_o, ea);
    chk("R10 we", 32'(mem_we_o), 32'(st));
    if (st) begin
      chk("R10 be", 32'(mem_be_o), 32'(exp_be));
      chk("R10 wdata", mem_wdata_o, exp_wd);
    end
    @(negedge clk_i);
    req_valid_i = 1'b0;
    repeat (lat) @(negedge clk_i);
    chk("R11 early done", 32'(done_o), 32'd0);
    mem_rvalid_i = 1'b1; mem_rdata_i = rw;
    @(negedge clk_i);
    mem_rvalid_i = 1'b0; mem_rdata_i = 32'hDEAD_BEEF;
    chk("R11 done", 32'(done_o), 32'd1);
    chk("R11 ld_we", 32'(ld_we_o), 32'(!st));
    if (!st) chk(sz == 0 ? "R7" : (sz == 1 ? "R8" : "R9"), ld_data_o, exp_ld);
    if (upd && bidx != 0) begin
      chk("R5 we", 32'(base_we_o), 32'd1);
      chk("R5 idx", 32'(base_wb_idx_o), 32'(bidx));
      chk("R5 val", base_wb_val_o, ea);
    end else begin
      chk("R5 no wb", 32'(base_we_o), 32'd0);
    end
    chk("R6 invalid", 32'(invalid_o), 32'(upd && bidx == 0));
    @(negedge clk_i);
    chk("R11 done pulse", 32'(done_o), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk("reset mem_req", 32'(mem_req_o), 32'd0);
    chk("reset done", 32'(done_o), 32'd0);
    chk("reset base_we", 32'(base_we_o), 32'd0);
    rst_ni = 1'b1;
    for (int st = 0; st < 2; st++)
      for (int m = 0; m < 3; m++)
        for (int bs = 0; bs < 2; bs++)
          for (int up = 0; up < 2; up++)
            for (int sz = 0; sz < 3; sz++)
              for (int off = 0; off < 4; off++)
                for (int sx = 0; sx < 2; sx++)
                  do_op(st[0], m, up[0], sz, sx[0], bs ? 5'd5 : 5'd0,
                        32'h1000_0000 + 32'(off), 16'hFFF0, 32'h0000_0104,
                        32'hA1B2_C3D4, off[0] ? 32'h1234_ABCD : 32'hF08C_7A13,
                        1 + ((off + sz) % 3));
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      checks++; fails++;
      $display("FAIL R11 watchdog act=hung exp=done");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end
endmodule